// File: doc/BRIEF.md
# Adaptive JTAG Clock Master

This block drives the four scan wires of a JTAG target from the probe side. Each request carries from 1 to 32 bits. For each bit the block presents a TMS value and a TDI value, then issues one TCK pulse. It collects the TDO bit that comes back for each pulse and returns the captured bits with the first bit in bit 0.

The block has two clocking modes. In echo mode, every TCK edge is held until the target's returned clock shows that it has followed the previous edge. The returned clock passes through a synchroniser before the block looks at it. With this handshake the scan rate follows whatever rate the target core can accept. In divider mode the returned clock is ignored. Each TCK half period is then a programmable number of block-clock cycles, so TCK can be set well below the target core rate.

Two reset outputs complete the block. An active-low test reset follows a request level. A system reset request produces an open-drain low pulse whose minimum length is derived from the block clock frequency. A watchdog on the echo handshake aborts a shift whose target never answers.

Top module: `ajtag_master`

## Requirements
- R1: While reset is applied, jtag_tck is 0, jtag_trst_n is 0 (test reset active), sys_rst_drive_low is 0, and shift_busy and shift_done are both 0.
- R2: In echo mode (cfg_adaptive=1), the next TCK edge is released only once the synchronised echo level equals the current TCK level. If the echo is held constant, TCK stays where it is. With an echo that repeats TCK after D block cycles, each TCK high time and each low time between pulses is exactly D+3 block cycles.
- R3: Bit 0 of shift_tms and shift_tdi is presented before the first TCK rise. Bit i+1 is presented in the same cycle as the TCK fall that ends pulse i, which is also the cycle in which the rising echo is accepted. jtag_tms and jtag_tdi never change while jtag_tck is high.
- R4: With cfg_tdo_fall=0, TDO is sampled when the rising echo of pulse i is accepted (in divider mode: at the end of the high phase) and stored in shift_tdo bit i. Bits at or above the request length read 0.
- R5: With cfg_tdo_fall=1, TDO is sampled when the falling echo of pulse i is accepted (in divider mode: at the end of the low phase) and stored in shift_tdo bit i.
- R6: In divider mode (cfg_adaptive=0), each TCK high phase and each low phase between pulses lasts max(cfg_half,1) block cycles, whatever the echo does.
- R7: A shift_start taken while idle with shift_len from 1 to 32 produces exactly shift_len TCK pulses. shift_busy stays high from the cycle after the start until shift_done, and shift_done is a one-cycle pulse. A shift_len of 0 is ignored, and a shift_len above 32 is treated as 32.
- R8: In echo mode with cfg_timeout nonzero, a phase that sees no echo for cfg_timeout+1 cycles ends the shift. TCK goes low, shift_err goes to 1, shift_done pulses, and shift_busy clears. With cfg_timeout=0 the block waits for as long as it takes. shift_err clears on the next accepted start.
- R9: A shift_start raised while shift_busy is high has no effect on the shift in progress.
- R10: One cycle after trst_req is sampled at 1, jtag_trst_n is 0. One cycle after trst_req is sampled at 0 (outside reset), jtag_trst_n is 1.
- R11: A cycle with srst_req=1 makes sys_rst_drive_low 1 for the following SRST_CYCLES = (CLK_FREQ_HZ/1e6)*SRST_US cycles. A new request during the pulse restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_adaptive | input | 1 | 1: echo-paced TCK; 0: divider-paced TCK |
| cfg_tdo_fall | input | 1 | 1: capture TDO on the falling echo; 0: on the rising echo |
| cfg_half | input | HALF_W | TCK half period in divider mode, in block cycles (0 acts as 1) |
| cfg_timeout | input | TO_W | Echo wait limit in cycles; 0 disables the watchdog |
| shift_start | input | 1 | Request strobe, taken only while idle |
| shift_len | input | LEN_W | Number of bits to shift (1..MAX_BITS) |
| shift_tms | input | MAX_BITS | TMS values, bit 0 first |
| shift_tdi | input | MAX_BITS | TDI values, bit 0 first |
| shift_busy | output | 1 | A shift is in progress |
| shift_done | output | 1 | One-cycle end-of-shift pulse |
| shift_err | output | 1 | The last shift was aborted by the echo watchdog |
| shift_tdo | output | MAX_BITS | Captured TDO bits, bit 0 first |
| trst_req | input | 1 | Level request for the test reset |
| srst_req | input | 1 | System reset pulse request |
| tck_echo | input | 1 | Returned test clock from the target |
| jtag_tdo | input | 1 | Test data from the target |
| jtag_tck | output | 1 | Test clock |
| jtag_tms | output | 1 | Test mode select |
| jtag_tdi | output | 1 | Test data to the target |
| jtag_trst_n | output | 1 | Active-low test reset |
| sys_rst_drive_low | output | 1 | Open-drain enable: 1 pulls the system reset line low, 0 releases it |

## Verification
The handshake property assumes that cfg_adaptive and the other configuration inputs are held steady while a shift is busy. It also assumes that, in echo mode, the returned clock only ever repeats TCK. The only exception is a deliberately frozen echo, which the watchdog turns into a flagged abort. The bench meets these assumptions by writing configuration only between shifts. Its target model is a plain delay line from TCK to the echo, and it freezes the echo only in the watchdog tests. The bench shifts TDO on each falling echo, as a real target would. This lets the captured-bit expectations be worked out arithmetically: pattern bit i for rising capture and bit i+1 for falling capture. Divider-mode tests with falling capture use half periods long enough that the target has already shifted TDO before the sample is taken.

// File: rtl/ajtag_pkg.sv
package ajtag_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HIGH  = 2'd2,
    PH_LOW   = 2'd3
  } phase_t;
endpackage

// File: rtl/ajtag_edge_sync.sv
module ajtag_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise,
  output logic fall
);
  // chain_q[0..STAGES-1] synchronise, chain_q[STAGES] holds the previous level
  logic [STAGES:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign lvl  = chain_q[STAGES-1];
  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/ajtag_rst_pulse.sv
module ajtag_rst_pulse #(
  parameter  int CYCLES = 25000,
  localparam int CW     = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic drive
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (req)              cnt_d = CW'(CYCLES);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign drive = (cnt_q != '0);
endmodule

// File: rtl/ajtag_shift_core.sv
module ajtag_shift_core
  import ajtag_pkg::*;
#(
  parameter  int MAX_BITS = 32,
  parameter  int HALF_W   = 8,
  parameter  int TO_W     = 16,
  localparam int LEN_W    = $clog2(MAX_BITS + 1),
  localparam int IDX_W    = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1,
  localparam int CNT_W    = (TO_W > HALF_W) ? TO_W : HALF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_adaptive,
  input  logic                cfg_tdo_fall,
  input  logic [HALF_W-1:0]   cfg_half,
  input  logic [TO_W-1:0]     cfg_timeout,
  input  logic                start,
  input  logic [LEN_W-1:0]    len,
  input  logic [MAX_BITS-1:0] tms_vec,
  input  logic [MAX_BITS-1:0] tdi_vec,
  input  logic                echo_lvl,
  input  logic                echo_rise,
  input  logic                echo_fall,
  input  logic                tdo_in,
  output logic                tck,
  output logic                tms,
  output logic                tdi,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [MAX_BITS-1:0] tdo_vec
);
  phase_t              ph_q, ph_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [IDX_W-1:0]    idx_q, idx_d, last_q, last_d;
  logic [MAX_BITS-1:0] tms_q, tms_vd, tdi_q, tdi_vd, tdo_q, tdo_d;
  logic                tck_q, tck_d, tmso_q, tmso_d, tdio_q, tdio_d;
  logic                done_q, done_d, err_q, err_d;

  logic [HALF_W-1:0]   half_eff;
  logic [CNT_W:0]      cnt_ext;
  logic                half_hit, to_hit, ev;
  logic [LEN_W-1:0]    len_eff;
  logic [IDX_W-1:0]    idx_nx;

  assign half_eff = (cfg_half == '0) ? HALF_W'(1) : cfg_half;
  assign cnt_ext  = {1'b0, cnt_q} + 1'b1;
  assign half_hit = cnt_ext >= (CNT_W+1)'(half_eff);
  assign to_hit   = cfg_adaptive && (cfg_timeout != '0) && (cnt_q == CNT_W'(cfg_timeout));
  assign len_eff  = (len > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : len;
  assign idx_nx   = idx_q + 1'b1;

  // phase completion event
  always_comb begin
    unique case (ph_q)
      PH_SETUP: ev = half_hit && (!cfg_adaptive || !echo_lvl);
      PH_HIGH:  ev = cfg_adaptive ? echo_rise : half_hit;
      PH_LOW:   ev = cfg_adaptive ? echo_fall : half_hit;
      default:  ev = 1'b0;
    endcase
  end

  // next state
  always_comb begin
    ph_d   = ph_q;
    cnt_d  = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
    idx_d  = idx_q;
    last_d = last_q;
    tms_vd = tms_q;
    tdi_vd = tdi_q;
    tdo_d  = tdo_q;
    tck_d  = tck_q;
    tmso_d = tmso_q;
    tdio_d = tdio_q;
    done_d = 1'b0;
    err_d  = err_q;
    unique case (ph_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start && (len != '0)) begin
          ph_d   = PH_SETUP;
          tms_vd = tms_vec;
          tdi_vd = tdi_vec;
          last_d = IDX_W'(len_eff - 1'b1);
          idx_d  = '0;
          tmso_d = tms_vec[0];
          tdio_d = tdi_vec[0];
          tdo_d  = '0;
          err_d  = 1'b0;
        end
      end
      PH_SETUP: begin
        if (ev) begin
          ph_d  = PH_HIGH;
          tck_d = 1'b1;
          cnt_d = '0;
        end else if (to_hit) begin
          ph_d = PH_IDLE; tck_d = 1'b0; err_d = 1'b1; done_d = 1'b1;
        end
      end
      PH_HIGH: begin
        if (ev) begin
          if (!cfg_tdo_fall) tdo_d[idx_q] = tdo_in;
          if (idx_q != last_q) begin
            tmso_d = tms_q[idx_nx];
            tdio_d = tdi_q[idx_nx];
          end
          ph_d  = PH_LOW;
          tck_d = 1'b0;
          cnt_d = '0;
        end else if (to_hit) begin
          ph_d = PH_IDLE; tck_d = 1'b0; err_d = 1'b1; done_d = 1'b1;
        end
      end
      PH_LOW: begin
        if (ev) begin
          if (cfg_tdo_fall) tdo_d[idx_q] = tdo_in;
          cnt_d = '0;
          if (idx_q == last_q) begin
            ph_d   = PH_IDLE;
            done_d = 1'b1;
          end else begin
            idx_d = idx_nx;
            ph_d  = PH_HIGH;
            tck_d = 1'b1;
          end
        end else if (to_hit) begin
          ph_d = PH_IDLE; tck_d = 1'b0; err_d = 1'b1; done_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      last_q <= '0;
      tms_q  <= '0;
      tdi_q  <= '0;
      tdo_q  <= '0;
      tck_q  <= 1'b0;
      tmso_q <= 1'b0;
      tdio_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      tms_q  <= tms_vd;
      tdi_q  <= tdi_vd;
      tdo_q  <= tdo_d;
      tck_q  <= tck_d;
      tmso_q <= tmso_d;
      tdio_q <= tdio_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign tck     = tck_q;
  assign tms     = tmso_q;
  assign tdi     = tdio_q;
  assign busy    = (ph_q != PH_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign tdo_vec = tdo_q;
endmodule

// File: rtl/ajtag_master.sv
module ajtag_master #(
  parameter  int MAX_BITS    = 32,
  parameter  int HALF_W      = 8,
  parameter  int TO_W        = 16,
  parameter  int SYNC_STAGES = 2,
  parameter  int CLK_FREQ_HZ = 50_000_000,
  parameter  int SRST_US     = 500,
  localparam int LEN_W       = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_adaptive,
  input  logic                cfg_tdo_fall,
  input  logic [HALF_W-1:0]   cfg_half,
  input  logic [TO_W-1:0]     cfg_timeout,
  input  logic                shift_start,
  input  logic [LEN_W-1:0]    shift_len,
  input  logic [MAX_BITS-1:0] shift_tms,
  input  logic [MAX_BITS-1:0] shift_tdi,
  output logic                shift_busy,
  output logic                shift_done,
  output logic                shift_err,
  output logic [MAX_BITS-1:0] shift_tdo,
  input  logic                trst_req,
  input  logic                srst_req,
  input  logic                tck_echo,
  input  logic                jtag_tdo,
  output logic                jtag_tck,
  output logic                jtag_tms,
  output logic                jtag_tdi,
  output logic                jtag_trst_n,
  output logic                sys_rst_drive_low
);
  localparam int SRST_CYCLES = (CLK_FREQ_HZ / 1_000_000) * SRST_US;

  logic [1:0] rsync_q, rsync_d;
  logic       rst_n_i;
  logic       echo_lvl, echo_rise, echo_fall;
  logic       trst_q, trst_d;

  // reset: asynchronous assertion, synchronous release
  always_comb rsync_d = {rsync_q[0], 1'b1};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= rsync_d;
  end
  assign rst_n_i = rsync_q[1];

  ajtag_edge_sync #(.STAGES(SYNC_STAGES)) u_echo (
    .clk  (clk),
    .rst_n(rst_n_i),
    .d    (tck_echo),
    .lvl  (echo_lvl),
    .rise (echo_rise),
    .fall (echo_fall)
  );

  ajtag_shift_core #(
    .MAX_BITS(MAX_BITS), .HALF_W(HALF_W), .TO_W(TO_W)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .cfg_adaptive(cfg_adaptive),
    .cfg_tdo_fall(cfg_tdo_fall),
    .cfg_half    (cfg_half),
    .cfg_timeout (cfg_timeout),
    .start       (shift_start),
    .len         (shift_len),
    .tms_vec     (shift_tms),
    .tdi_vec     (shift_tdi),
    .echo_lvl    (echo_lvl),
    .echo_rise   (echo_rise),
    .echo_fall   (echo_fall),
    .tdo_in      (jtag_tdo),
    .tck         (jtag_tck),
    .tms         (jtag_tms),
    .tdi         (jtag_tdi),
    .busy        (shift_busy),
    .done        (shift_done),
    .err         (shift_err),
    .tdo_vec     (shift_tdo)
  );

  ajtag_rst_pulse #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk  (clk),
    .rst_n(rst_n_i),
    .req  (srst_req),
    .drive(sys_rst_drive_low)
  );

  // test reset: held active through block reset, then follows the request
  always_comb trst_d = ~trst_req;
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) trst_q <= 1'b0;
    else          trst_q <= trst_d;
  end
  assign jtag_trst_n = trst_q;
endmodule

// File: rtl/ajtag_master_chk.sv
module ajtag_master_chk #(
  parameter  int SRST_CYCLES = 25000,
  localparam int SW          = $clog2(SRST_CYCLES + 2)
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_adaptive,
  input logic shift_start,
  input logic shift_busy,
  input logic shift_done,
  input logic shift_err,
  input logic jtag_tck,
  input logic jtag_tms,
  input logic jtag_tdi,
  input logic jtag_trst_n,
  input logic trst_req,
  input logic srst_req,
  input logic sys_rst_drive_low,
  input logic echo_lvl
);
  logic [SW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_q <= SW'(SRST_CYCLES);
    else if (srst_req)                   since_q <= '0;
    else if (since_q != SW'(SRST_CYCLES)) since_q <= since_q + 1'b1;
  end

  // R2
  echo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_adaptive && (jtag_tck != $past(jtag_tck)) && !shift_err) |-> ($past(echo_lvl) == $past(jtag_tck)));
  // R3
  tms_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(jtag_tms) |-> !jtag_tck);
  // R3
  tdi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(jtag_tdi) |-> !jtag_tck);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_done |=> !shift_done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_busy) |-> shift_done);
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_busy) |-> $past(shift_start));
  // R8
  idle_tck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_busy |-> !jtag_tck);
  // R10
  trst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trst_req) |-> !jtag_trst_n);
  // R11
  srst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_drive_low) |-> $past(srst_req));
  // R11
  srst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_drive_low) |-> (since_q == SW'(SRST_CYCLES)));
endmodule

bind ajtag_master ajtag_master_chk #(.SRST_CYCLES(SRST_CYCLES)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cfg_adaptive     (cfg_adaptive),
  .shift_start      (shift_start),
  .shift_busy       (shift_busy),
  .shift_done       (shift_done),
  .shift_err        (shift_err),
  .jtag_tck         (jtag_tck),
  .jtag_tms         (jtag_tms),
  .jtag_tdi         (jtag_tdi),
  .jtag_trst_n      (jtag_trst_n),
  .trst_req         (trst_req),
  .srst_req         (srst_req),
  .sys_rst_drive_low(sys_rst_drive_low),
  .echo_lvl         (echo_lvl)
);

// File: tb/tb_ajtag_master.sv
module tb_ajtag_master;
  localparam int CLK_PERIOD = 10;
  localparam int SRST_CYC   = 500;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_adaptive, cfg_tdo_fall;
  logic [7:0]  cfg_half;
  logic [15:0] cfg_timeout;
  logic        shift_start;
  logic [5:0]  shift_len;
  logic [31:0] shift_tms, shift_tdi;
  logic        shift_busy, shift_done, shift_err;
  logic [31:0] shift_tdo;
  logic        trst_req, srst_req;
  logic        tck_echo, jtag_tdo;
  logic        jtag_tck, jtag_tms, jtag_tdi, jtag_trst_n, sys_rst_drive_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  ajtag_master #(.CLK_FREQ_HZ(1_000_000), .SRST_US(500)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_adaptive(cfg_adaptive), .cfg_tdo_fall(cfg_tdo_fall),
    .cfg_half(cfg_half), .cfg_timeout(cfg_timeout), .shift_start(shift_start),
    .shift_len(shift_len), .shift_tms(shift_tms), .shift_tdi(shift_tdi),
    .shift_busy(shift_busy), .shift_done(shift_done), .shift_err(shift_err),
    .shift_tdo(shift_tdo), .trst_req(trst_req), .srst_req(srst_req),
    .tck_echo(tck_echo), .jtag_tdo(jtag_tdo), .jtag_tck(jtag_tck), .jtag_tms(jtag_tms),
    .jtag_tdi(jtag_tdi), .jtag_trst_n(jtag_trst_n), .sys_rst_drive_low(sys_rst_drive_low)
  );

  // target model: echo is TCK delayed by dly cycles, TDO shifts on each falling echo
  int          dly = 2;
  logic        stuck = 1'b0;
  logic [3:0]  pipe = '0;
  logic        echo_prev = 1'b0;
  logic [5:0]  tgt_idx = '0;
  logic [63:0] tdo_pat = '0;

  assign tck_echo = stuck ? 1'b0 : pipe[dly-1];
  assign jtag_tdo = tdo_pat[tgt_idx];

  always @(posedge clk) begin
    pipe      <= {pipe[2:0], jtag_tck};
    echo_prev <= tck_echo;
    if (shift_start && !shift_busy)  tgt_idx <= '0;
    else if (echo_prev && !tck_echo) tgt_idx <= tgt_idx + 1'b1;
  end

  // monitor (samples at the falling clock edge)
  int          checks = 0, fails = 0, cyc = 0;
  int          pulses = 0, hi_run = 0, lo_run = 0;
  int          hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;
  int          done_cnt = 0, srst_cnt = 0;
  logic        tck_prev = 1'b0;
  logic [31:0] tms_seen = '0, tdi_seen = '0;

  always @(negedge clk) begin
    cyc++;
    if (shift_start && !shift_busy) begin
      pulses = 0; hi_run = 0; lo_run = 0;
      hi_min = 1000; hi_max = 0; lo_min = 1000; lo_max = 0;
      tms_seen = '0; tdi_seen = '0;
    end else begin
      if (jtag_tck && !tck_prev) begin
        if (pulses > 0) begin
          if (lo_run < lo_min) lo_min = lo_run;
          if (lo_run > lo_max) lo_max = lo_run;
        end
        if (pulses < 32) begin
          tms_seen[pulses] = jtag_tms;
          tdi_seen[pulses] = jtag_tdi;
        end
        pulses++;
        hi_run = 1;
      end else if (jtag_tck) hi_run++;
      if (!jtag_tck && tck_prev) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
        lo_run = 1;
      end else if (!jtag_tck) lo_run++;
    end
    tck_prev = jtag_tck;
    if (shift_done) done_cnt++;
    if (sys_rst_drive_low) srst_cnt++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run_shift(input int len, input logic [31:0] tms, input logic [31:0] tdi);
    int d0, w;
    shift_len = 6'(len); shift_tms = tms; shift_tdi = tdi;
    d0 = done_cnt;
    shift_start = 1'b1; tick(); shift_start = 1'b0;
    w = 0;
    while (done_cnt == d0 && w < 5000) begin tick(); w++; end
  endtask

  function automatic logic [31:0] len_mask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
  endfunction

  function automatic logic [31:0] exp_tdo(input int len, input bit fall, input logic [63:0] pat);
    logic [31:0] e = '0;
    for (int i = 0; i < len; i++) e[i] = fall ? pat[i+1] : pat[i];
    return e;
  endfunction

  initial begin
    int lens[5] = '{1, 2, 5, 17, 32};
    int halves[3] = '{3, 4, 7};
    logic [31:0] tms, tdi;
    int d0, s0;

    rst_n = 1'b0; cfg_adaptive = 1'b1; cfg_tdo_fall = 1'b0; cfg_half = 8'd4;
    cfg_timeout = 16'd100; shift_start = 1'b0; shift_len = '0; shift_tms = '0;
    shift_tdi = '0; trst_req = 1'b0; srst_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(jtag_tck == 0 && jtag_trst_n == 0 && sys_rst_drive_low == 0 && shift_busy == 0 && shift_done == 0,
        "R1 reset outputs", {jtag_tck, jtag_trst_n, sys_rst_drive_low, shift_busy, shift_done}, 0);
    tick(); rst_n = 1'b1;
    repeat (5) tick();
    chk(jtag_trst_n == 1, "R10 trst released", jtag_trst_n, 1);

    // R2 R3 R4 R5 R7: echo-paced sweep over delay, capture edge and length
    for (int d = 1; d <= 4; d++) begin
      for (int f = 0; f < 2; f++) begin
        for (int li = 0; li < 5; li++) begin
          dly = d; cfg_adaptive = 1'b1; cfg_tdo_fall = f[0];
          tms = 32'h9E37_79B9 ^ (32'h0101_0101 * d) ^ {16'(li), 16'h0};
          tdi = ~tms ^ 32'h5A5A_3C3C ^ (32'd1 << li);
          tdo_pat = {64'hD1B5_4A32_6C9E_F087} ^ (64'd7 << (lens[li] + d));
          repeat (3) tick();
          run_shift(lens[li], tms, tdi);
          chk(pulses == lens[li], "R7 pulse count", pulses, lens[li]);
          chk(shift_err == 0 && shift_busy == 0, "R7 clean finish", {shift_err, shift_busy}, 0);
          chk((tms_seen & len_mask(lens[li])) == (tms & len_mask(lens[li])), "R3 tms order",
              tms_seen & len_mask(lens[li]), tms & len_mask(lens[li]));
          chk((tdi_seen & len_mask(lens[li])) == (tdi & len_mask(lens[li])), "R3 tdi order",
              tdi_seen & len_mask(lens[li]), tdi & len_mask(lens[li]));
          if (f == 0) chk(shift_tdo == exp_tdo(lens[li], 1'b0, tdo_pat), "R4 rising capture",
                          shift_tdo, exp_tdo(lens[li], 1'b0, tdo_pat));
          else        chk(shift_tdo == exp_tdo(lens[li], 1'b1, tdo_pat), "R5 falling capture",
                          shift_tdo, exp_tdo(lens[li], 1'b1, tdo_pat));
          chk(hi_min == d + 3 && hi_max == d + 3, "R2 high time", hi_max, d + 3);
          if (lens[li] > 1) chk(lo_min == d + 3 && lo_max == d + 3, "R2 low time", lo_max, d + 3);
        end
      end
    end

    // R6: divider mode
    for (int h = 0; h < 3; h++) begin
      for (int f = 0; f < 2; f++) begin
        dly = 1; cfg_adaptive = 1'b0; cfg_tdo_fall = f[0]; cfg_half = 8'(halves[h]);
        tdo_pat = 64'h3C96_A55A_0FF0_C3E1 >> h;
        repeat (3) tick();
        run_shift(8, 32'h0000_00B4, 32'h0000_0069);
        chk(hi_min == halves[h] && hi_max == halves[h], "R6 divider high", hi_max, halves[h]);
        chk(lo_min == halves[h] && lo_max == halves[h], "R6 divider low", lo_max, halves[h]);
        chk(shift_tdo == exp_tdo(8, f[0], tdo_pat), f ? "R5 divider capture" : "R4 divider capture",
            shift_tdo, exp_tdo(8, f[0], tdo_pat));
      end
    end
    cfg_half = 8'd0; cfg_tdo_fall = 1'b0;
    repeat (3) tick();
    run_shift(4, 32'h5, 32'hA);
    chk(hi_max == 1 && lo_max == 1 && pulses == 4, "R6 zero half acts as one", {hi_max[7:0], lo_max[7:0]}, 16'h0101);

    // R8: frozen echo with watchdog
    cfg_adaptive = 1'b1; cfg_timeout = 16'd5; dly = 2;
    repeat (3) tick();
    stuck = 1'b1;
    run_shift(4, 32'hF, 32'h0);
    chk(shift_err == 1, "R8 error flag", shift_err, 1);
    chk(pulses == 1 && hi_max == 6, "R8 abort after timeout+1", {pulses[7:0], hi_max[7:0]}, 16'h0106);
    tick();
    chk(jtag_tck == 0 && shift_busy == 0, "R8 idle after abort", {jtag_tck, shift_busy}, 0);

    // R8 R2: watchdog disabled, TCK held until the echo returns
    stuck = 1'b0; cfg_timeout = 16'd0;
    repeat (10) tick();
    stuck = 1'b1;
    d0 = done_cnt;
    shift_len = 6'd2; shift_tms = '0; shift_tdi = '0;
    shift_start = 1'b1; tick(); shift_start = 1'b0;
    repeat (300) tick();
    chk(shift_busy == 1 && pulses == 1 && jtag_tck == 1 && done_cnt == d0, "R2 held without echo",
        {shift_busy, jtag_tck, pulses[7:0]}, {2'b11, 8'd1});
    stuck = 1'b0;
    repeat (100) tick();
    chk(done_cnt == d0 + 1 && pulses == 2 && shift_err == 0, "R8 disabled watchdog completes",
        {done_cnt - d0, pulses}, {32'd1, 32'd2});

    // R9: start while busy ignored
    cfg_timeout = 16'd100;
    d0 = done_cnt;
    shift_len = 6'd3; shift_tms = 32'h2; shift_tdi = 32'h1;
    shift_start = 1'b1; tick(); shift_start = 1'b0;
    repeat (6) tick();
    shift_len = 6'd10; shift_start = 1'b1; tick(); shift_start = 1'b0;
    repeat (200) tick();
    chk(pulses == 3 && done_cnt == d0 + 1, "R9 busy start ignored", pulses, 3);

    // R7: zero length and over-length requests
    d0 = done_cnt;
    shift_len = 6'd0; shift_start = 1'b1; tick(); shift_start = 1'b0;
    repeat (20) tick();
    chk(done_cnt == d0 && pulses == 0 && shift_busy == 0, "R7 zero length ignored", pulses, 0);
    run_shift(40, 32'hFFFF_0000, 32'h0000_FFFF);
    chk(pulses == 32, "R7 length clamp", pulses, 32);

    // R10: test reset follows request
    trst_req = 1'b1; repeat (3) tick();
    chk(jtag_trst_n == 0, "R10 trst asserted", jtag_trst_n, 0);
    trst_req = 1'b0; repeat (3) tick();
    chk(jtag_trst_n == 1, "R10 trst released again", jtag_trst_n, 1);

    // R11: system reset pulse and retrigger
    s0 = srst_cnt;
    srst_req = 1'b1; tick(); srst_req = 1'b0;
    repeat (SRST_CYC + 50) tick();
    chk(srst_cnt - s0 == SRST_CYC, "R11 pulse length", srst_cnt - s0, SRST_CYC);
    s0 = srst_cnt;
    srst_req = 1'b1; tick(); srst_req = 1'b0;
    repeat (199) tick();
    srst_req = 1'b1; tick(); srst_req = 1'b0;
    repeat (SRST_CYC + 50) tick();
    chk(srst_cnt - s0 == 200 + SRST_CYC, "R11 retrigger extends", srst_cnt - s0, 200 + SRST_CYC);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule